// File: doc/BRIEF.md
# Triggered Pipeline Readout Buffer

This block holds every bunch crossing's worth of link data in a delay line whose length is programmable, so that the data is still available when the Level-1 trigger decision arrives. Each clock is one bunch crossing. All links are stored side by side in one wide word, each link carrying 16 data bits and one valid bit. When a Level-1 accept is sampled, the word leaving the delay line in that cycle is copied into a 256-entry readout FIFO.

A downstream readout controller drains the FIFO one event at a time. A readout-start strobe opens an event, and the block places a header word on the 16-bit bus that holds the event's valid pattern, one bit per link. The link words then follow, one for each request/acknowledge handshake. Back-pressure has two rules. The readout side sets the pace entirely: a word leaves only when the controller raises and then drops request. On the trigger side the block never stalls: an accept that finds the FIFO full is lost, and this is recorded.

Top module: `trig_readout_buf`

## Requirements
- R1: An accept sampled at clock edge t stores the link data and valid bits that were sampled at edge t-d, where d is the programmed depth. A depth of 0 means a delay of 512.
- R2: Within a stored word, link k uses data bits [16k+15:16k] of `lk_data` and valid bit k of `lk_valid`. Readout sends link 0 first and the highest link last.
- R3: A depth write clears the delay line's fill state. An accept sampled before edge W+d+1, where W is the edge of the write, stores an entry that is all zeros, including its valid pattern. `pipe_status` bit 14 (empty) is 1 right after the write, and bit 15 (primed) becomes 1 once d edges have passed.
- R4: `pipe_status` bits 8:0 read back the depth. The depth is 4 after reset.
- R5: `fifo_status` bits 7:0 hold the entry count modulo 256, bit 15 is full and bit 14 is empty. With 256 entries the status reads full with a count field of 0.
- R6: An accept that arrives while the FIFO is full is dropped and leaves the stored entries unchanged. It sets `fifo_status` bit 13, which stays set until reset.
- R7: A start strobe while the block is idle and the FIFO is not empty makes `ro_busy` 1 from the next cycle. In that same cycle `ro_data` carries the valid pattern in its low bits, with zeros above. A start strobe while the FIFO is empty is ignored.
- R8: `ro_ack` rises one clock after `ro_req` is sampled high. It stays high while `ro_req` stays high, and it falls one clock after `ro_req` is sampled low.
- R9: While `ro_ack` is high, `ro_data` carries the current link word. After the acknowledge for the last link falls, the entry leaves the FIFO and `ro_busy` returns to 0.
- R10: A request while the block is not busy gets no acknowledge.
- R11: After reset the FIFO is empty, the overflow bit is clear, and `ro_busy`, `ro_ack` and `ro_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_data | input | 48 | Link data, 16 bits per link |
| lk_valid | input | 3 | Per-link valid bits |
| l1a | input | 1 | Level-1 accept |
| cfg_we | input | 1 | Depth write strobe, which also flushes the delay line |
| cfg_depth | input | 9 | New depth value |
| pipe_status | output | 16 | Primed, empty and depth |
| fifo_status | output | 16 | Full, empty, overflow and count |
| ro_start | input | 1 | Readout start strobe |
| ro_req | input | 1 | Readout word request |
| ro_ack | output | 1 | Readout word acknowledge |
| ro_busy | output | 1 | An event readout is open |
| ro_data | output | 16 | Header or link word |

## Verification
The properties assume a well-behaved readout controller. It raises request only while an event is open and acknowledge is low, it holds request until it has seen acknowledge, and it drives start as a one-cycle pulse. The bench's readout task follows exactly this order, stepping one cycle per move. The only deliberate departures are the idle-request and empty-start cases, and there the checked outcome is the absence of a response. Depth writes and accepts are driven at chosen offsets from the write edge, so every expected entry is a plain function of the crossing number.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  typedef enum logic [1:0] {
    RO_IDLE,
    RO_HDR,
    RO_WAIT,
    RO_ACK
  } ro_state_t;
endpackage

// File: rtl/tpr_pipe.sv
module tpr_pipe #(
  parameter int W  = 51,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] depth,
  output logic [W-1:0]  rd_data,
  output logic          primed,
  output logic          empty
);
  localparam int N = 1 << AW;
  localparam logic [AW:0] NFULL = (AW+1)'(N);

  logic [W-1:0]  mem [N];
  logic [AW-1:0] wp;
  logic [AW:0]   fill;
  logic [AW:0]   eff;

  always_ff @(posedge clk) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      fill <= '0;
    end else begin
      wp <= wp + 1'b1;
      if (flush)              fill <= '0;
      else if (fill != NFULL) fill <= fill + 1'b1;
    end
  end

  // depth 0 selects the full ring length
  assign eff     = (depth == '0) ? NFULL : {1'b0, depth};
  assign primed  = (fill >= eff);
  assign empty   = (fill == '0);
  assign rd_data = mem[wp - depth];
endmodule

// File: rtl/tpr_fifo.sv
module tpr_fifo #(
  parameter int W  = 51,
  parameter int AW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [AW:0]  count,
  output logic         full,
  output logic         empty
);
  localparam int N = 1 << AW;
  localparam logic [AW:0] NFULL = (AW+1)'(N);

  logic [W-1:0]  mem [N];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == NFULL);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tpr_readout.sv
module tpr_readout
  import tpr_pkg::*;
#(
  parameter int LINKS = 3,
  parameter int LW    = 16,
  parameter int EW    = LINKS * LW + LINKS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req,
  input  logic          fifo_empty,
  input  logic [EW-1:0] head,
  output logic          pop,
  output logic          ack,
  output logic          busy,
  output logic [LW-1:0] data
);
  localparam int IW = (LINKS > 1) ? $clog2(LINKS) : 1;
  localparam logic [IW-1:0] LAST = IW'(LINKS - 1);

  ro_state_t     st;
  logic [IW-1:0] idx;
  logic [LINKS-1:0] vpat;
  logic [LW-1:0] words [LINKS];

  assign vpat = head[EW-1 -: LINKS];

  for (genvar k = 0; k < LINKS; k++) begin : g_word
    assign words[k] = head[k*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RO_IDLE;
      idx <= '0;
    end else begin
      case (st)
        RO_IDLE: if (start && !fifo_empty) st <= RO_HDR;
        RO_HDR, RO_WAIT: if (req) st <= RO_ACK;
        RO_ACK: if (!req) begin
          if (idx == LAST) begin
            idx <= '0;
            st  <= RO_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= RO_WAIT;
          end
        end
        default: st <= RO_IDLE;
      endcase
    end
  end

  assign ack  = (st == RO_ACK);
  assign busy = (st != RO_IDLE);
  assign pop  = (st == RO_ACK) && !req && (idx == LAST);

  always_comb begin
    data = '0;
    case (st)
      RO_HDR:          data = LW'(vpat);
      RO_WAIT, RO_ACK: data = words[idx];
      default:         data = '0;
    endcase
  end
endmodule

// File: rtl/trig_readout_buf.sv
module trig_readout_buf #(
  parameter int LINKS     = 3,
  parameter int LW        = 16,
  parameter int PIPE_AW   = 9,
  parameter int FIFO_AW   = 8,
  parameter int DEF_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINKS*LW-1:0]   lk_data,
  input  logic [LINKS-1:0]      lk_valid,
  input  logic                  l1a,
  input  logic                  cfg_we,
  input  logic [PIPE_AW-1:0]    cfg_depth,
  output logic [15:0]           pipe_status,
  output logic [15:0]           fifo_status,
  input  logic                  ro_start,
  input  logic                  ro_req,
  output logic                  ro_ack,
  output logic                  ro_busy,
  output logic [LW-1:0]         ro_data
);
  localparam int EW   = LINKS * LW + LINKS;
  localparam int PPAD = 14 - PIPE_AW;
  localparam int FPAD = 13 - FIFO_AW;

  logic [PIPE_AW-1:0] depth_r;
  logic               ovf_r;
  logic [EW-1:0]      pipe_out, entry_in, head;
  logic               primed, p_empty;
  logic [FIFO_AW:0]   cnt;
  logic               f_full, f_empty, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_r <= PIPE_AW'(DEF_DEPTH);
      ovf_r   <= 1'b0;
    end else begin
      if (cfg_we)          depth_r <= cfg_depth;
      if (l1a && f_full)   ovf_r   <= 1'b1;
    end
  end

  tpr_pipe #(.W(EW), .AW(PIPE_AW)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (cfg_we),
    .wr_data ({lk_valid, lk_data}),
    .depth   (depth_r),
    .rd_data (pipe_out),
    .primed  (primed),
    .empty   (p_empty)
  );

  // stale words before the line is primed are replaced by zeros
  assign entry_in = primed ? pipe_out : '0;

  tpr_fifo #(.W(EW), .AW(FIFO_AW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (l1a),
    .pop   (pop),
    .wdata (entry_in),
    .rdata (head),
    .count (cnt),
    .full  (f_full),
    .empty (f_empty)
  );

  tpr_readout #(.LINKS(LINKS), .LW(LW), .EW(EW)) u_ro (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ro_start),
    .req        (ro_req),
    .fifo_empty (f_empty),
    .head       (head),
    .pop        (pop),
    .ack        (ro_ack),
    .busy       (ro_busy),
    .data       (ro_data)
  );

  assign pipe_status = {primed, p_empty, {PPAD{1'b0}}, depth_r};
  assign fifo_status = {f_full, f_empty, ovf_r, {FPAD{1'b0}}, cnt[FIFO_AW-1:0]};
endmodule

// File: rtl/tpr_checker.sv
module tpr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        l1a,
  input logic        ro_start,
  input logic        ro_req,
  input logic        ro_ack,
  input logic        ro_busy,
  input logic [15:0] fifo_status
);
  // R8: acknowledge only rises after a sampled request
  a_r8_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ro_ack) |-> $past(ro_req));
  // R8: acknowledge held while request stays high
  a_r8_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_ack && ro_req) |=> ro_ack);
  // R8: acknowledge falls one clock after request drops
  a_r8_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_ack && !ro_req) |=> !ro_ack);
  // R10: no acknowledge outside an open event
  a_r10_ack_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ro_ack |-> ro_busy);
  // R7: an event opens only on a start strobe
  a_r7_open_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!ro_busy && !ro_start) |=> !ro_busy);
  // R7: an open event always has its entry in the FIFO
  a_r7_busy_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ro_busy |-> !fifo_status[14]);
  // R5: full and empty never together
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_status[15] && fifo_status[14]));
  // R6: accept into a full FIFO raises overflow
  a_r6_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a && fifo_status[15]) |=> fifo_status[13]);
  // R6: overflow is sticky
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_status[13] |=> fifo_status[13]);
endmodule

bind trig_readout_buf tpr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .l1a         (l1a),
  .ro_start    (ro_start),
  .ro_req      (ro_req),
  .ro_ack      (ro_ack),
  .ro_busy     (ro_busy),
  .fifo_status (fifo_status)
);

// File: tb/test_trig_readout_buf.sv
`timescale 1ns/1ps
module test_trig_readout_buf;
  localparam int EW = 51;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] lk_data = '0;
  logic [2:0]  lk_valid = '0;
  logic        l1a = 1'b0, cfg_we = 1'b0;
  logic [8:0]  cfg_depth = '0;
  logic        ro_start = 1'b0, ro_req = 1'b0;
  logic [15:0] pipe_status, fifo_status, ro_data;
  logic        ro_ack, ro_busy;

  int tick = 0, tests = 0, fails = 0, mcnt = 0, wedge = 0, eff = 4;
  logic [EW-1:0] exp_q[$];

  trig_readout_buf i_trig_readout_buf (
    .clk(clk), .rst_n(rst_n), .lk_data(lk_data), .lk_valid(lk_valid),
    .l1a(l1a), .cfg_we(cfg_we), .cfg_depth(cfg_depth),
    .pipe_status(pipe_status), .fifo_status(fifo_status),
    .ro_start(ro_start), .ro_req(ro_req), .ro_ack(ro_ack),
    .ro_busy(ro_busy), .ro_data(ro_data)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] fdat(int t, int k);
    return 16'((t * 37 + k * 4099 + 11) & 16'hFFFF);
  endfunction
  function automatic logic [2:0] fval(int t);
    return 3'((t * 5 + 1) % 8);
  endfunction
  function automatic logic [EW-1:0] entry_at(int t);
    return {fval(t), fdat(t, 2), fdat(t, 1), fdat(t, 0)};
  endfunction

  task automatic check(string r, logic [63:0] act, logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, expv);
    end
  endtask

  task automatic step;
    @(negedge clk);
    tick++;
    l1a = 1'b0; ro_start = 1'b0; cfg_we = 1'b0;
    for (int k = 0; k < 3; k++) lk_data[k*16 +: 16] = fdat(tick, k);
    lk_valid = fval(tick);
  endtask

  // accept at the current tick; model of R1, R3, R6
  task automatic record_l1a;
    logic [EW-1:0] e;
    l1a = 1'b1;
    if (tick >= wedge + eff + 1) e = entry_at(tick - eff);
    else e = '0;
    if (mcnt < 256) begin
      exp_q.push_back(e);
      mcnt++;
    end
  endtask

  task automatic readout;
    logic [EW-1:0] e;
    e = exp_q.pop_front();
    mcnt--;
    step; ro_start = 1'b1;
    step;
    check("R7 busy after start", 64'(ro_busy), 64'd1);
    check("R7 header pattern", 64'(ro_data), 64'(e[50:48]));
    for (int k = 0; k < 3; k++) begin
      ro_req = 1'b1;
      step;
      check("R8 ack rises", 64'(ro_ack), 64'd1);
      check("R9 R2 link word", 64'(ro_data), 64'(e[k*16 +: 16]));
      ro_req = 1'b0;
      step;
      check("R8 ack falls", 64'(ro_ack), 64'd0);
    end
    check("R9 event closed", 64'(ro_busy), 64'd0);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) step;
    rst_n = 1'b1;
    wedge = tick - 1; eff = 4;
    exp_q.delete(); mcnt = 0;
    step;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ds[6] = '{1, 2, 3, 5, 7, 0};
    do_reset;
    // R11, R4, R5 reset state
    check("R11 fifo status", 64'(fifo_status), 64'h4000);
    check("R4 default depth", 64'(pipe_status[8:0]), 64'd4);
    check("R11 busy", 64'(ro_busy), 64'd0);
    check("R11 ack", 64'(ro_ack), 64'd0);
    check("R11 data", 64'(ro_data), 64'd0);

    // R1, R3: depth sweep including the 512 wrap case
    foreach (ds[i]) begin
      step;
      cfg_we = 1'b1; cfg_depth = 9'(ds[i]);
      wedge = tick; eff = (ds[i] == 0) ? 512 : ds[i];
      forever begin
        step;
        if (tick == wedge + 1)
          check("R3 R4 status after write", 64'(pipe_status), 64'(16'h4000 | ds[i]));
        if (tick == wedge + eff) begin
          check("R3 not yet primed", 64'(pipe_status[15]), 64'd0);
          record_l1a;
        end else if (tick == wedge + eff + 1) begin
          check("R3 primed", 64'(pipe_status[15]), 64'd1);
          record_l1a;
        end else if (tick == wedge + eff + 3) begin
          record_l1a;
          break;
        end
      end
      step;
      check("R5 count three", 64'(fifo_status), 64'h0003);
      repeat (3) readout;
      check("R5 empty again", 64'(fifo_status), 64'h4000);
    end

    // R7, R10: ignored stimulus with empty FIFO
    step; ro_start = 1'b1;
    step; step;
    check("R7 start on empty ignored", 64'(ro_busy), 64'd0);
    ro_req = 1'b1;
    step; step;
    check("R10 idle request ignored", 64'(ro_ack), 64'd0);
    ro_req = 1'b0;
    step;

    // R5, R6: fill to 256, overflow, drain
    step;
    cfg_we = 1'b1; cfg_depth = 9'd1;
    wedge = tick; eff = 1;
    repeat (3) step;
    for (int n = 0; n < 256; n++) begin
      record_l1a;
      step;
    end
    check("R5 full count field", 64'(fifo_status), 64'h8000);
    record_l1a;
    step;
    check("R6 overflow flagged", 64'(fifo_status), 64'hA000);
    for (int n = 0; n < 256; n++) readout;
    check("R6 sticky after drain", 64'(fifo_status), 64'h6000);
    do_reset;
    check("R6 cleared by reset", 64'(fifo_status), 64'h4000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule